// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the single tearing-effect line driven by a display panel and turns it into a frame-transfer trigger. The panel signals both horizontal and vertical sync on the same wire, and the block tells them apart by how long each pulse lasts. Width is counted in ticks of a divided clock enable that the caller provides. A short pulse is a horizontal sync. A pulse that stays active long enough is a vertical sync.

After each vertical sync the block counts horizontal syncs as display lines. It raises a one-cycle active-low match pulse when the programmed trigger condition holds. There are two trigger conditions: every vertical sync, or the moment the line count reaches a programmed target line. A transfer engine waits for the falling edge of the match output before it starts moving a frame. The configuration arrives as one static word. A separate enable input gates the whole detector.

Top module: `te_sync_detect`

## Requirements
- R1: While and after reset, with no qualifying pulse, `match_n_o` is high and the line count is zero.
- R2: Vertical sync is measured on the pin XOR `cfg_i[28]`, and horizontal sync on the pin XOR `cfg_i[29]`. With both bits set, an idle-high pin with low-going pulses behaves exactly like the non-inverted case.
- R3: A vertical sync is recognised on the tick at which an active run reaches V = (`cfg_i[14:3]` + 1) × 8 ticks. A run of V − 1 ticks is not a vertical sync.
- R4: A horizontal sync is recognised when an active run ends after 1 to H ticks, where H = `cfg_i[2:0]` + 1. A run longer than H that stays below V is ignored.
- R5: A vertical sync clears the line count. Without vertical syncs the count is never cleared.
- R6: Each horizontal sync not paired with a vertical sync raises the line count by one. The count saturates at its maximum.
- R7: With trigger mode `cfg_i[27:26]` = 3, every vertical sync produces a match.
- R8: With trigger mode 2, a match occurs when a horizontal sync brings the line count to the target `cfg_i[25:15]`. With a target of 0, the match occurs on the vertical sync instead.
- R9: With trigger mode 0 or 1, or with `te_en_i` low, no match is produced and the width and line counters stay cleared.
- R10: A match drives `match_n_o` low for exactly one clock, in the cycle after the qualifying event. Measured from the pin, this is 2 synchroniser stages plus the width count plus one output register.
- R11: Pulse widths advance only on cycles where `tick_i` is high, so a pulse of W ticks at any divider setting from 1 to 8 classifies the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_pin_i | input | 1 | Raw tearing-effect line from the panel |
| tick_i | input | 1 | Divided tick enable, one clock wide |
| te_en_i | input | 1 | Master enable for the tearing logic |
| cfg_i | input | 30 | [2:0] short limit, [14:3] long limit in units of 8, [25:15] target line, [27:26] trigger mode, [28] vertical invert, [29] horizontal invert |
| match_n_o | output | 1 | Active-low one-cycle match pulse |

## Verification
The embedded assertions check, on every cycle, the local invariants:
- a vertical sync fires once per run;
- a width counter moves only on ticks and clears after a horizontal event;
- a vertical sync clears the line count, and a horizontal sync steps it by one;
- a frame-mode vertical sync yields a match on the next cycle;
- a match never appears while the detector is disabled or without a preceding event.

Only the bench scenarios can show the end-to-end behaviour:
- the exact classification boundaries at V − 1/V and H/H + 1;
- the line-target hit counts over whole frames;
- equivalence under inverted polarity and a divided tick;
- the exact pin-to-match latency.

// File: rtl/te_pkg.sv
package te_pkg;

  localparam int CFG_W  = 30;
  localparam int LINE_W = 11;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_RSVD  = 2'd1,
    TRIG_LINE  = 2'd2,
    TRIG_FRAME = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic              hs_inv;
    logic              vs_inv;
    trig_mode_e        mode;
    logic [LINE_W-1:0] target;
    logic [11:0]       vfield;
    logic [2:0]        hfield;
  } te_cfg_t;

  function automatic te_cfg_t te_unpack(input logic [CFG_W-1:0] raw);
    te_cfg_t c;
    c.hs_inv = raw[29];
    c.vs_inv = raw[28];
    c.mode   = trig_mode_e'(raw[27:26]);
    c.target = raw[25:15];
    c.vfield = raw[14:3];
    c.hfield = raw[2:0];
    return c;
  endfunction

endpackage

// File: rtl/te_sync_in.sv
module te_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int CNT_W     = 16,
  parameter bit LONG_KIND = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             evt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lvl;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign lvl = en_i & (pin_i ^ inv_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!lvl) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl;
    end
  end

  generate
    if (LONG_KIND) begin : g_long
      assign evt_o = lvl & tick_i & (cnt_q == (limit_i - 1'b1));

      // R3: a long run yields its event once only
      a_r3_long_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
    end else begin : g_short
      assign evt_o = en_i & lvl_q & ~lvl & (cnt_q != '0) & (cnt_q <= limit_i);

      // R4: a short event marks the end of a run, so the count restarts
      a_r4_short_clears: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (cnt_q == '0));
    end
  endgenerate

  // R11: without a tick the width either holds or restarts at zero
  a_r11_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ((cnt_q == '0) || (cnt_q == $past(cnt_q))));

endmodule

// File: rtl/te_line_track.sv
module te_line_track
  import te_pkg::*;
#(
  parameter int LW = LINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  trig_mode_e    mode_i,
  input  logic [LW-1:0] target_i,
  input  logic          vs_evt_i,
  input  logic          hs_evt_i,
  output logic          match_n_o
);

  localparam logic [LW-1:0] LINE_MAX = '1;

  logic [LW-1:0] line_q;
  logic [LW-1:0] line_d;
  logic          hit;
  logic          match_n_q;

  always_comb begin
    line_d = line_q;
    hit    = 1'b0;
    if (!en_i) begin
      line_d = '0;
    end else if (vs_evt_i) begin
      line_d = '0;
      hit    = (mode_i == TRIG_FRAME) ||
               ((mode_i == TRIG_LINE) && (target_i == '0));
    end else if (hs_evt_i) begin
      if (line_q != LINE_MAX) line_d = line_q + 1'b1;
      hit = (mode_i == TRIG_LINE) && (line_d == target_i) && (line_d != line_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      match_n_q <= 1'b1;
    end else begin
      line_q    <= line_d;
      match_n_q <= ~hit;
    end
  end

  assign match_n_o = match_n_q;

  // R5
  a_r5_vsync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vs_evt_i) |=> (line_q == '0));

  // R6
  a_r6_hsync_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && hs_evt_i && !vs_evt_i && (line_q != LINE_MAX)) |=>
      (line_q == $past(line_q) + 1'b1));

  // R7
  a_r7_frame_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vs_evt_i && (mode_i == TRIG_FRAME)) |=> !match_n_o);

  // R9
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> match_n_o);

  // R10: a match always follows an enabled event one cycle earlier
  a_r10_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    !match_n_o |-> $past(en_i && (vs_evt_i || hs_evt_i)));

endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
  import te_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             te_pin_i,
  input  logic             tick_i,
  input  logic             te_en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             match_n_o
);

  localparam int HF_W = 3;
  localparam int VF_W = 12;

  te_cfg_t          cfg;
  logic             pin_s;
  logic             active;
  logic [CNT_W-1:0] h_lim;
  logic [CNT_W-1:0] v_lim;
  logic             vs_evt;
  logic             hs_evt;

  assign cfg    = te_unpack(cfg_i);
  assign active = te_en_i && ((cfg.mode == TRIG_LINE) || (cfg.mode == TRIG_FRAME));
  assign h_lim  = CNT_W'(cfg.hfield) + CNT_W'(1);
  assign v_lim  = (CNT_W'(cfg.vfield) + CNT_W'(1)) << 3;

  te_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (te_pin_i),
    .q_o   (pin_s)
  );

  te_pulse_meter #(.CNT_W(CNT_W), .LONG_KIND(1'b1)) u_vmeter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (active),
    .tick_i  (tick_i),
    .pin_i   (pin_s),
    .inv_i   (cfg.vs_inv),
    .limit_i (v_lim),
    .evt_o   (vs_evt)
  );

  te_pulse_meter #(.CNT_W(CNT_W), .LONG_KIND(1'b0)) u_hmeter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (active),
    .tick_i  (tick_i),
    .pin_i   (pin_s),
    .inv_i   (cfg.hs_inv),
    .limit_i (h_lim),
    .evt_o   (hs_evt)
  );

  te_line_track #(.LW(LINE_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (active),
    .mode_i    (cfg.mode),
    .target_i  (cfg.target),
    .vs_evt_i  (vs_evt),
    .hs_evt_i  (hs_evt),
    .match_n_o (match_n_o)
  );

  localparam int UNUSED_W = HF_W + VF_W;
  initial begin
    assert (CNT_W >= 16) else $error("CNT_W too small for %0d-bit limits", UNUSED_W);
  end

endmodule

// File: tb/te_sync_detect_tb.sv
module te_sync_detect_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        te_pin;
  logic        tick;
  logic        te_en;
  logic [29:0] cfg;
  logic        match_n;

  int checks   = 0;
  int failures = 0;
  int div      = 1;
  int tcnt     = 0;
  bit count_on = 1'b0;
  int lows     = 0;
  int falls    = 0;
  logic prev_m = 1'b1;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  te_sync_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .te_pin_i  (te_pin),
    .tick_i    (tick),
    .te_en_i   (te_en),
    .cfg_i     (cfg),
    .match_n_o (match_n)
  );

  always @(negedge clk) begin
    tcnt <= (tcnt >= div - 1) ? 0 : tcnt + 1;
    tick <= (tcnt >= div - 1);
  end

  always @(posedge clk) begin
    if (count_on && !match_n) lows++;
    if (count_on && prev_m && !match_n) falls++;
    prev_m <= match_n;
  end

  // columns: en div hf vf mode tgt inv vw nh hw frames expected
  localparam int NV = 13;
  localparam int TBL [0:NV-1][0:11] = '{
    '{1,1,1,0,3,0,0, 8,5,2,3,3},  // R7
    '{1,1,1,0,2,3,0, 8,5,2,3,3},  // R8 R6
    '{1,1,1,0,2,6,0, 8,5,2,3,0},  // R8 unreachable line
    '{1,1,1,0,0,0,0, 8,5,2,3,0},  // R9 mode off
    '{1,1,1,0,1,0,0, 8,5,2,3,0},  // R9 reserved mode
    '{0,1,1,0,3,0,0, 8,5,2,3,0},  // R9 disabled
    '{1,1,1,0,3,0,0, 7,5,2,3,0},  // R3 V-1
    '{1,1,1,0,2,2,0, 8,5,3,3,0},  // R4 H+1 ignored
    '{1,1,1,0,2,4,3, 8,4,2,2,2},  // R2 inverted
    '{1,3,0,1,3,0,0,16,3,1,2,2},  // R11 divided tick
    '{1,1,1,0,2,0,0, 8,5,2,2,2},  // R8 target zero
    '{1,1,7,1,2,2,0,16,5,8,2,2},  // R4 H=8 boundary
    '{1,1,1,1,2,2,0,15,5,2,2,1}   // R5 no vsync clear
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic idle);
    rst_n  = 1'b0;
    te_pin = idle;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse(input logic idle, input int ticks);
    te_pin = ~idle;
    repeat (ticks * div) @(negedge clk);
    te_pin = idle;
    repeat (4 * div) @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    logic idle;
    idle  = (TBL[i][6] != 0);
    div   = TBL[i][1];
    te_en = TBL[i][0][0];
    cfg   = '0;
    cfg[29]    = TBL[i][6][1];
    cfg[28]    = TBL[i][6][0];
    cfg[27:26] = TBL[i][4][1:0];
    cfg[25:15] = TBL[i][5][10:0];
    cfg[14:3]  = TBL[i][3][11:0];
    cfg[2:0]   = TBL[i][2][2:0];
    do_reset(idle);
    lows = 0; falls = 0; count_on = 1'b1;
    for (int f = 0; f < TBL[i][10]; f++) begin
      pulse(idle, TBL[i][7]);
      for (int h = 0; h < TBL[i][8]; h++) pulse(idle, TBL[i][9]);
    end
    repeat (10) @(negedge clk);
    count_on = 1'b0;
    check($sformatf("R7/R8/R9 vector %0d match count", i), falls, TBL[i][11]);
    check($sformatf("R10 vector %0d one-cycle pulses", i), lows, falls);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    te_en = 1'b1;
    cfg   = 30'h0C00_0000;
    div   = 1;
    rst_n = 1'b0;
    te_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 match high in reset", int'(match_n), 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 match high after reset", int'(match_n), 1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10 latency: frame mode, V = 8 ticks, tick every cycle
    div   = 1;
    te_en = 1'b1;
    cfg   = '0;
    cfg[27:26] = 2'd3;
    do_reset(1'b0);
    te_pin = 1'b1;
    repeat (9) @(posedge clk);
    @(negedge clk);
    check("R10 no match before latency", int'(match_n), 1);
    @(posedge clk);
    @(negedge clk);
    check("R10 match in expected cycle", int'(match_n), 0);
    @(posedge clk);
    @(negedge clk);
    check("R10 match released after one cycle", int'(match_n), 1);
    repeat (20) @(negedge clk);
    te_pin = 1'b0;
    repeat (10) @(negedge clk);
    check("R3 no second match on same run", int'(match_n), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule